// File: doc/BRIEF.md
# ONU Receiver Power-State Controller

This block decides when the receive side of an optical network unit may power down. A header detector upstream of it presents a one-cycle strobe together with a sleep-request bit. While the unit is Active, a strobe with the request bit set starts a fixed power-saving cycle with three stages: Sleep, while the transceivers shut down; Low Power, while they stay off; and Wake, while they come back up and resynchronise. At the end of Wake the unit returns to Active. Each stage lasts a fixed number of clock cycles. Nothing cuts a stage short, and no header can start or alter the cycle once it has begun.

Downstream data is admitted only while Active. Frames that arrive during Low Power are dropped, not held. The transceiver power enable is removed only in Low Power. Four saturating counters record how many cycles the unit has spent in each state, so that software-independent statistics can show how much of the time the receiver stayed powered down. A single clear input zeroes all four counters. At the 156.25 MHz system clock, the default intervals are 450, 6200 and 700 cycles.

Top module: `onu_power_ctrl`

## Requirements
- R1: After reset, pwrState reads Active, rxEnable and xcvrPowerEn are high, and all four cycle counters are zero. The state encoding is 2'b00 Active, 2'b01 Sleep, 2'b10 Low Power and 2'b11 Wake.
- R2: In Active, a cycle with hdrValid=1 and hdrSleep=1 makes pwrState read Sleep (2'b01) from the next cycle on.
- R3: In Active, a header with hdrSleep=0, or hdrSleep=1 with hdrValid=0, leaves pwrState at Active.
- R4: Sleep lasts exactly SLEEP_CYCLES cycles (default 450), and then pwrState reads Low Power (2'b10).
- R5: Low Power lasts exactly LOWPWR_CYCLES cycles (default 6200), and then pwrState reads Wake (2'b11).
- R6: Wake lasts exactly WAKE_CYCLES cycles (default 700), and then pwrState reads Active.
- R7: Headers seen in Sleep, Low Power or Wake have no effect on the state or on the length of the current interval.
- R8: rxEnable is high exactly while pwrState is Active.
- R9: xcvrPowerEn is low exactly while pwrState is Low Power.
- R10: On each clock edge without statClear, the counter of the state current before the edge increases by one, and the other counters hold their values.
- R11: A counter that holds its all-ones value stays there.
- R12: statClear zeroes all four counters on the next edge. A clear takes priority over the increment of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | One-cycle strobe: a control header was detected |
| hdrSleep | input | 1 | Sleep-request bit of the header |
| statClear | input | 1 | Zeroes all state cycle counters |
| pwrState | output | 2 | Current state (00 Active, 01 Sleep, 10 Low Power, 11 Wake) |
| rxEnable | output | 1 | Downstream data admitted |
| xcvrPowerEn | output | 1 | Transceiver power enable |
| activeCycles | output | STAT_W | Cycles spent in Active |
| sleepCycles | output | STAT_W | Cycles spent in Sleep |
| lowPowerCycles | output | STAT_W | Cycles spent in Low Power |
| wakeCycles | output | STAT_W | Cycles spent in Wake |

## Verification
The assertions check on every cycle that a sleep request enters Sleep and that anything else keeps the unit Active. A run-length counter in the checker shows that no timed state ends before or after its interval. The assertions also check that the enables change only at the expected transitions and that the counters increment, saturate and clear as specified. The bench scenarios show what the assertions cannot: that headers sent deep inside Low Power and Wake leave the interval unchanged, the absolute counter totals after a full power cycle, and saturation on a narrow-counter instance.

// File: rtl/onu_pwr_pkg.sv
package onu_pwr_pkg;

  localparam int NUM_STATES = 4;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'b00,
    ST_SLEEP  = 2'b01,
    ST_LOWPWR = 2'b10,
    ST_WAKE   = 2'b11
  } pwr_state_e;

  // Strobes passed from the control FSM to the statistics datapath
  typedef struct packed {
    logic                  clear;
    logic [NUM_STATES-1:0] stateHot;
  } stat_strobe_t;

endpackage

// File: rtl/onu_pwr_ctrl.sv
module onu_pwr_ctrl
  import onu_pwr_pkg::*;
#(
  parameter int SLEEP_CYCLES  = 450,
  parameter int LOWPWR_CYCLES = 6200,
  parameter int WAKE_CYCLES   = 700
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hdrValid,
  input  logic         hdrSleep,
  input  logic         statClear,
  output pwr_state_e   stateQ,
  output stat_strobe_t strobes
);

  localparam int MAX_A  = (SLEEP_CYCLES > LOWPWR_CYCLES) ? SLEEP_CYCLES : LOWPWR_CYCLES;
  localparam int MAX_IV = (MAX_A > WAKE_CYCLES) ? MAX_A : WAKE_CYCLES;
  localparam int TMR_W  = (MAX_IV > 1) ? $clog2(MAX_IV) : 1;

  logic [TMR_W-1:0] timerQ;
  pwr_state_e       stateNxt;
  logic             timerDone;

  function automatic logic [TMR_W-1:0] loadFor(pwr_state_e s);
    case (s)
      ST_SLEEP:  return TMR_W'(SLEEP_CYCLES - 1);
      ST_LOWPWR: return TMR_W'(LOWPWR_CYCLES - 1);
      ST_WAKE:   return TMR_W'(WAKE_CYCLES - 1);
      default:   return '0;
    endcase
  endfunction

  assign timerDone = (timerQ == '0);

  always_comb begin
    stateNxt = stateQ;
    case (stateQ)
      ST_ACTIVE: if (hdrValid && hdrSleep) stateNxt = ST_SLEEP;
      ST_SLEEP:  if (timerDone) stateNxt = ST_LOWPWR;
      ST_LOWPWR: if (timerDone) stateNxt = ST_WAKE;
      ST_WAKE:   if (timerDone) stateNxt = ST_ACTIVE;
      default:   stateNxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_ACTIVE;
      timerQ <= '0;
    end else begin
      stateQ <= stateNxt;
      if (stateNxt != stateQ)
        timerQ <= loadFor(stateNxt);
      else if (!timerDone)
        timerQ <= timerQ - 1'b1;
    end
  end

  always_comb begin
    strobes.clear    = statClear;
    strobes.stateHot = '0;
    strobes.stateHot[stateQ] = 1'b1;
  end

endmodule

// File: rtl/onu_pwr_stats.sv
module onu_pwr_stats
  import onu_pwr_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  stat_strobe_t      strobes,
  output logic [STAT_W-1:0] counts [NUM_STATES]
);

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_cnt
    logic [STAT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clear)
        cntQ <= '0;
      else if (strobes.stateHot[g] && (cntQ != '1))
        cntQ <= cntQ + 1'b1;
    end
    assign counts[g] = cntQ;
  end

endmodule

// File: rtl/onu_power_ctrl.sv
module onu_power_ctrl
  import onu_pwr_pkg::*;
#(
  parameter int SLEEP_CYCLES  = 450,
  parameter int LOWPWR_CYCLES = 6200,
  parameter int WAKE_CYCLES   = 700,
  parameter int STAT_W        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic              hdrSleep,
  input  logic              statClear,
  output logic [1:0]        pwrState,
  output logic              rxEnable,
  output logic              xcvrPowerEn,
  output logic [STAT_W-1:0] activeCycles,
  output logic [STAT_W-1:0] sleepCycles,
  output logic [STAT_W-1:0] lowPowerCycles,
  output logic [STAT_W-1:0] wakeCycles
);

  pwr_state_e        stateQ;
  stat_strobe_t      strobes;
  logic [STAT_W-1:0] counts [NUM_STATES];

  onu_pwr_ctrl #(
    .SLEEP_CYCLES (SLEEP_CYCLES),
    .LOWPWR_CYCLES(LOWPWR_CYCLES),
    .WAKE_CYCLES  (WAKE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hdrValid (hdrValid),
    .hdrSleep (hdrSleep),
    .statClear(statClear),
    .stateQ   (stateQ),
    .strobes  (strobes)
  );

  onu_pwr_stats #(.STAT_W(STAT_W)) u_stats (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .counts (counts)
  );

  assign pwrState       = stateQ;
  assign rxEnable       = (stateQ == ST_ACTIVE);
  assign xcvrPowerEn    = (stateQ != ST_LOWPWR);
  assign activeCycles   = counts[ST_ACTIVE];
  assign sleepCycles    = counts[ST_SLEEP];
  assign lowPowerCycles = counts[ST_LOWPWR];
  assign wakeCycles     = counts[ST_WAKE];

endmodule

// File: rtl/onu_pwr_checker.sv
module onu_pwr_checker #(
  parameter int SLEEP_CYCLES  = 450,
  parameter int LOWPWR_CYCLES = 6200,
  parameter int WAKE_CYCLES   = 700,
  parameter int STAT_W        = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hdrValid,
  input logic              hdrSleep,
  input logic              statClear,
  input logic [1:0]        pwrState,
  input logic              rxEnable,
  input logic              xcvrPowerEn,
  input logic [STAT_W-1:0] activeCycles,
  input logic [STAT_W-1:0] sleepCycles,
  input logic [STAT_W-1:0] lowPowerCycles,
  input logic [STAT_W-1:0] wakeCycles
);

  // Run length of the current state, counting the present cycle
  logic [1:0] lastSt;
  int unsigned runReg;
  int unsigned curRun;

  assign curRun = (pwrState == lastSt) ? runReg + 1 : 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSt <= 2'b00;
      runReg <= 0;
    end else begin
      lastSt <= pwrState;
      runReg <= curRun;
    end
  end

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b00 && hdrValid && hdrSleep) |=> pwrState == 2'b01);

  a_r3_hold_active: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b00 && !(hdrValid && hdrSleep)) |=> pwrState == 2'b00);

  a_r4_sleep_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b01 && curRun < SLEEP_CYCLES) |=> pwrState == 2'b01);

  a_r4_sleep_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b01 && curRun == SLEEP_CYCLES) |=> pwrState == 2'b10);

  a_r5_lowpwr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b10 && curRun < LOWPWR_CYCLES) |=> pwrState == 2'b10);

  a_r5_lowpwr_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b10 && curRun == LOWPWR_CYCLES) |=> pwrState == 2'b11);

  a_r6_wake_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b11 && curRun < WAKE_CYCLES) |=> pwrState == 2'b11);

  a_r6_wake_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b11 && curRun == WAKE_CYCLES) |=> pwrState == 2'b00);

  a_r8_rx_reopen: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> $past(pwrState) == 2'b11);

  a_r9_power_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xcvrPowerEn) |-> $past(pwrState) == 2'b01);

  a_r10_sleep_count: assert property (@(posedge clk) disable iff (!rstN)
    (!statClear && pwrState == 2'b01 && sleepCycles != '1)
      |=> sleepCycles == $past(sleepCycles) + 1'b1);

  a_r10_other_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!statClear && pwrState == 2'b01) |=> $stable(activeCycles) && $stable(wakeCycles));

  a_r11_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (!statClear && activeCycles == '1) |=> activeCycles == '1);

  a_r12_clear: assert property (@(posedge clk) disable iff (!rstN)
    statClear |=> (activeCycles == '0 && sleepCycles == '0 &&
                   lowPowerCycles == '0 && wakeCycles == '0));

endmodule

bind onu_power_ctrl onu_pwr_checker #(
  .SLEEP_CYCLES (SLEEP_CYCLES),
  .LOWPWR_CYCLES(LOWPWR_CYCLES),
  .WAKE_CYCLES  (WAKE_CYCLES),
  .STAT_W       (STAT_W)
) u_chk (.*);

// File: tb/test_onu_power_ctrl.sv
module test_onu_power_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 1'b0;
  logic hdrSleep = 1'b0;
  logic statClear = 1'b0;
  logic [1:0]  pwrState;
  logic        rxEnable, xcvrPowerEn;
  logic [31:0] activeCycles, sleepCycles, lowPowerCycles, wakeCycles;

  logic        nClear = 1'b0;
  logic [1:0]  nState;
  logic        nRx, nPwr;
  logic [3:0]  nAct, nSlp, nLp, nWk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  onu_power_ctrl i_onu_power_ctrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrSleep(hdrSleep),
    .statClear(statClear), .pwrState(pwrState), .rxEnable(rxEnable),
    .xcvrPowerEn(xcvrPowerEn), .activeCycles(activeCycles),
    .sleepCycles(sleepCycles), .lowPowerCycles(lowPowerCycles),
    .wakeCycles(wakeCycles)
  );

  // Narrow-counter instance for saturation
  onu_power_ctrl #(.SLEEP_CYCLES(3), .LOWPWR_CYCLES(4), .WAKE_CYCLES(2), .STAT_W(4))
  i_onu_power_ctrl_sat (
    .clk(clk), .rstN(rstN), .hdrValid(1'b0), .hdrSleep(1'b0),
    .statClear(nClear), .pwrState(nState), .rxEnable(nRx),
    .xcvrPowerEn(nPwr), .activeCycles(nAct), .sleepCycles(nSlp),
    .lowPowerCycles(nLp), .wakeCycles(nWk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkState(input string req, input logic [1:0] exp);
    chk(req, {30'd0, pwrState}, {30'd0, exp});
    chk("R8", {31'd0, rxEnable}, {31'd0, exp == 2'b00});
    chk("R9", {31'd0, xcvrPowerEn}, {31'd0, exp != 2'b10});
  endtask

  typedef struct packed {
    logic        v;
    logic        s;
    logic [15:0] waitN;
    logic [1:0]  exp;
  } vec_t;

  // Each row: one header cycle, then waitN idle cycles, then check state
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 16'd0,    2'b01},  // R2 enter Sleep
    '{1'b0, 1'b0, 16'd448,  2'b01},  // R4 last Sleep cycle
    '{1'b0, 1'b0, 16'd0,    2'b10},  // R4 Low Power
    '{1'b1, 1'b1, 16'd6198, 2'b10},  // R5/R7 last Low Power cycle
    '{1'b0, 1'b0, 16'd0,    2'b11},  // R5 Wake
    '{1'b1, 1'b1, 16'd698,  2'b11},  // R6/R7 last Wake cycle
    '{1'b0, 1'b0, 16'd0,    2'b00},  // R6 Active
    '{1'b1, 1'b0, 16'd5,    2'b00},  // R3 control bit 0
    '{1'b0, 1'b1, 16'd3,    2'b00},  // R3 no strobe
    '{1'b1, 1'b1, 16'd0,    2'b01}   // R2 enter Sleep again
  };
  localparam string TAGS [NV] = '{"R2", "R4", "R4", "R7", "R5", "R7", "R6", "R3", "R3", "R2"};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkState("R1", 2'b00);
    chk("R1", activeCycles, 0);
    chk("R1", sleepCycles | lowPowerCycles | wakeCycles, 0);

    for (int i = 0; i < NV; i++) begin
      hdrValid = VECS[i].v;
      hdrSleep = VECS[i].s;
      @(negedge clk);
      hdrValid = 1'b0;
      hdrSleep = 1'b0;
      repeat (int'(VECS[i].waitN)) @(negedge clk);
      chkState(TAGS[i], VECS[i].exp);
    end

    // R12: clear in Sleep wins over the increment
    statClear = 1'b1;
    @(negedge clk);
    statClear = 1'b0;
    chk("R12", activeCycles | sleepCycles | lowPowerCycles | wakeCycles, 0);
    // wait for the rest of the cycle back to Active
    while (pwrState != 2'b00) @(negedge clk);
    statClear = 1'b1;
    @(negedge clk);
    statClear = 1'b0;
    chk("R12", activeCycles | sleepCycles | lowPowerCycles | wakeCycles, 0);

    // R10: ten Active cycles
    repeat (10) @(negedge clk);
    chk("R10", activeCycles, 10);
    chk("R10", sleepCycles, 0);
    hdrValid = 1'b1; hdrSleep = 1'b1;
    @(negedge clk);
    hdrValid = 1'b0; hdrSleep = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", activeCycles, 11);
    chk("R10", sleepCycles, 5);
    while (pwrState != 2'b00) @(negedge clk);
    chk("R10", sleepCycles, 450);
    chk("R10", lowPowerCycles, 6200);
    chk("R10", wakeCycles, 700);
    chk("R10", activeCycles, 11);

    // R11: narrow counters saturate at 15
    nClear = 1'b1;
    @(negedge clk);
    nClear = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11", {28'd0, nAct}, 5);
    repeat (20) @(negedge clk);
    chk("R11", {28'd0, nAct}, 15);
    chk("R11", {28'd0, nSlp}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule